// File: doc/BRIEF.md
# Renaming Register Status File

This block is the architectural register file of a dynamically scheduled pipeline that renames in hardware. Each of its registers holds either a settled value or the tag of the reservation station that will produce the register's next value. An instruction being issued reads its two sources through two read ports. Each source comes back either as a ready value or as the producer tag to wait on. In the same cycle the block records the issuing station's tag against the destination register, which replaces any older tag still pending there.

The block watches the result broadcast bus. A broadcast writes a register only while that register still names the broadcasting station, so a result from a producer that has since been superseded is dropped. Only the last writer of a register updates it. A source read in the same cycle as a matching broadcast picks up the broadcast value directly.

Each register runs a two-state machine. In `ENT_READY` the register holds a valid value and a null tag. In `ENT_WAIT` it holds a pending producer tag. The transitions are: *rename* (`ENT_READY` to `ENT_WAIT` on an issue to this register), *retag* (`ENT_WAIT` to `ENT_WAIT` with the new tag on a further issue), *capture* (`ENT_WAIT` to `ENT_READY` on a matching broadcast with no issue to this register), and *hold* (the state stays as it is when neither event occurs).

Top module: `rrs_file`

## Requirements
- R1: After reset, whether at power-up or in the middle of a run, every register is ready with value 0 and tag 0.
- R2: A read of a ready register returns rdy=1, the stored value, and tag 0. Tag value 0 is the null tag.
- R3: A read of a waiting register, with no matching broadcast in that cycle, returns rdy=0, value 0, and the pending producer tag.
- R4: A read of a waiting register whose tag equals bc_tag while bc_valid is 1 returns rdy=1, value bc_data, and tag 0 in that same cycle.
- R5: An issue (iss_valid=1, iss_tag nonzero) leaves register iss_dst waiting on iss_tag from the next cycle on, replacing any older pending tag. Reads in the issue cycle still see the state from before the issue.
- R6: A matching broadcast stores bc_data into the waiting register, and the register reads as ready from the next cycle on.
- R7: A broadcast whose tag differs from a register's current tag leaves that register's value, tag and state unchanged. This includes a broadcast from a producer that has been superseded.
- R8: When an issue renames a register in the same cycle that a broadcast matches its old tag, the new tag is kept, the register stays waiting, and its value is not written.
- R9: An issue with iss_tag 0 is ignored. A broadcast with bc_valid 0 is ignored, and so is a broadcast with bc_tag 0.
- R10: A single broadcast completes every waiting register whose tag equals bc_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 2 | Destination register of the issuing instruction |
| iss_tag | input | 3 | Tag of the issuing station; 0 is null |
| rd_a_idx | input | 2 | Register index for source A |
| rd_b_idx | input | 2 | Register index for source B |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | 3 | Tag of the broadcasting station |
| bc_data | input | 32 | Broadcast result value |
| rd_a_rdy | output | 1 | Source A is a value (1) or a tag (0) |
| rd_a_val | output | 32 | Source A value; 0 when waiting |
| rd_a_tag | output | 3 | Source A producer tag; 0 when ready |
| rd_b_rdy | output | 1 | Source B is a value (1) or a tag (0) |
| rd_b_val | output | 32 | Source B value; 0 when waiting |
| rd_b_tag | output | 3 | Source B producer tag; 0 when ready |

## Verification
The bench renames a register twice and then broadcasts the older tag. A design that compared against any tag ever given to the register would accept that stale result and overwrite the newer pending one. It also issues a rename to a register in the same cycle as the broadcast that matches the register's old tag. A design that let the broadcast win would mark the register ready and lose the new producer. The same-cycle bypass is probed on both read ports, including the case where one broadcast completes two registers. A design without the bypass would report a tag for one cycle too long. Issues with a null tag, broadcasts with a null tag and broadcasts with valid low are all driven against registers with known values. Finally, a reset in the middle of a run must clear both pending and completed registers.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    // Per-register state: holding a settled value, or waiting on a producer tag.
    typedef enum logic {
        ENT_READY = 1'b0,
        ENT_WAIT  = 1'b1
    } ent_state_e;

endpackage

// File: rtl/rrs_entry.sv
module rrs_entry #(
    parameter int IDX    = 0,
    parameter int NREGS  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              pend,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] val
);
    import rrs_pkg::*;

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              rename;
    logic              hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            val_q   <= val_d;
        end
    end

    // Next-state logic
    always_comb begin
        rename  = iss_valid && (iss_dst == MY_IDX) && (iss_tag != '0);
        hit     = bc_valid && (bc_tag != '0) && (bc_tag == tag_q);
        state_d = state_q;
        tag_d   = tag_q;
        val_d   = val_q;
        unique case (state_q)
            ENT_READY: begin
                if (rename) begin           // rename
                    state_d = ENT_WAIT;
                    tag_d   = iss_tag;
                end
            end
            ENT_WAIT: begin
                if (rename) begin           // retag: newest producer wins
                    tag_d = iss_tag;
                end else if (hit) begin     // capture
                    state_d = ENT_READY;
                    tag_d   = '0;
                    val_d   = bc_data;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend = (state_q == ENT_WAIT);
        tag  = tag_q;
        val  = val_q;
    end

endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port #(
    parameter int NREGS  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [NREGS-1:0]             pend_vec,
    input  logic [NREGS-1:0][TAG_W-1:0]  tag_vec,
    input  logic [NREGS-1:0][DATA_W-1:0] val_vec,
    input  logic [IDX_W-1:0]             idx,
    input  logic                         bc_valid,
    input  logic [TAG_W-1:0]             bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    output logic                         rdy,
    output logic [TAG_W-1:0]             tag,
    output logic [DATA_W-1:0]            value
);
    logic              sel_pend;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;
    logic              bypass;

    always_comb begin
        sel_pend = pend_vec[idx];
        sel_tag  = tag_vec[idx];
        sel_val  = val_vec[idx];
        bypass   = sel_pend && bc_valid && (bc_tag != '0) && (bc_tag == sel_tag);
        if (!sel_pend) begin
            rdy   = 1'b1;
            value = sel_val;
            tag   = '0;
        end else if (bypass) begin
            rdy   = 1'b1;
            value = bc_data;
            tag   = '0;
        end else begin
            rdy   = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end

endmodule

// File: rtl/rrs_file.sv
module rrs_file #(
    parameter int NREGS  = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              rd_a_rdy,
    output logic [DATA_W-1:0] rd_a_val,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic              rd_b_rdy,
    output logic [DATA_W-1:0] rd_b_val,
    output logic [TAG_W-1:0]  rd_b_tag
);
    logic [NREGS-1:0]             pend_vec;
    logic [NREGS-1:0][TAG_W-1:0]  tag_vec;
    logic [NREGS-1:0][DATA_W-1:0] val_vec;

    for (genvar g = 0; g < NREGS; g++) begin : g_ent
        rrs_entry #(
            .IDX(g), .NREGS(NREGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_valid(iss_valid),
            .iss_dst  (iss_dst),
            .iss_tag  (iss_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .pend     (pend_vec[g]),
            .tag      (tag_vec[g]),
            .val      (val_vec[g])
        );
    end

    rrs_read_port #(
        .NREGS(NREGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_rd_a (
        .pend_vec(pend_vec), .tag_vec(tag_vec), .val_vec(val_vec),
        .idx(rd_a_idx), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rdy(rd_a_rdy), .tag(rd_a_tag), .value(rd_a_val)
    );

    rrs_read_port #(
        .NREGS(NREGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_rd_b (
        .pend_vec(pend_vec), .tag_vec(tag_vec), .val_vec(val_vec),
        .idx(rd_b_idx), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rdy(rd_b_rdy), .tag(rd_b_tag), .value(rd_b_val)
    );

endmodule

// File: rtl/rrs_file_chk.sv
module rrs_file_chk #(
    parameter int NREGS  = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         iss_valid,
    input logic [IDX_W-1:0]             iss_dst,
    input logic [TAG_W-1:0]             iss_tag,
    input logic [IDX_W-1:0]             rd_a_idx,
    input logic [IDX_W-1:0]             rd_b_idx,
    input logic                         bc_valid,
    input logic [TAG_W-1:0]             bc_tag,
    input logic [DATA_W-1:0]            bc_data,
    input logic                         rd_a_rdy,
    input logic [DATA_W-1:0]            rd_a_val,
    input logic [TAG_W-1:0]             rd_a_tag,
    input logic                         rd_b_rdy,
    input logic [DATA_W-1:0]            rd_b_val,
    input logic [TAG_W-1:0]             rd_b_tag,
    input logic [NREGS-1:0]             pend_vec,
    input logic [NREGS-1:0][TAG_W-1:0]  tag_vec,
    input logic [NREGS-1:0][DATA_W-1:0] val_vec
);

    // R5: an issue with a real tag leaves the destination waiting on it
    a_r5_rename: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_tag != '0) |=>
        (pend_vec[$past(iss_dst)] && tag_vec[$past(iss_dst)] == $past(iss_tag)));

    // R2: ready read returns stored value with null tag
    a_r2_ready_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_rdy && !pend_vec[rd_a_idx]) |-> (rd_a_val == val_vec[rd_a_idx] && rd_a_tag == '0));

    // R3: waiting read returns the producer tag and a zero value
    a_r3_wait_a: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_rdy |-> (rd_a_tag == tag_vec[rd_a_idx] && rd_a_val == '0));
    a_r3_wait_b: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_rdy |-> (rd_b_tag == tag_vec[rd_b_idx] && rd_b_val == '0));

    // R4: a ready answer for a waiting register can only come from the bus
    a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_rdy && pend_vec[rd_a_idx]) |->
        (bc_valid && bc_tag == tag_vec[rd_a_idx] && rd_a_val == bc_data));
    a_r4_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_rdy && pend_vec[rd_b_idx]) |->
        (bc_valid && bc_tag == tag_vec[rd_b_idx] && rd_b_val == bc_data && rd_b_tag == '0));

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic ren;
        logic hit;
        assign ren = iss_valid && (iss_dst == IDX_W'(i)) && (iss_tag != '0);
        assign hit = bc_valid && (bc_tag == tag_vec[i]);

        // R2: null tag exactly when the register holds a valid value
        a_r2_null_tag: assert property (@(posedge clk) disable iff (!rst_n)
            pend_vec[i] == (tag_vec[i] != '0));

        // R6 / R10: matching broadcast completes every waiting register
        a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[i] && hit && !ren) |=> (!pend_vec[i] && val_vec[i] == $past(bc_data)));

        // R7: a non-matching broadcast changes nothing
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[i] && !hit && !ren) |=>
            (pend_vec[i] && $stable(tag_vec[i]) && $stable(val_vec[i])));

        // R8: rename beats a same-cycle matching broadcast
        a_r8_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[i] && hit && ren) |=> (pend_vec[i] && $stable(val_vec[i])));

        // R9: a ready register is only disturbed by a real rename
        a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_vec[i] && !ren) |=> (!pend_vec[i] && $stable(val_vec[i])));
    end

endmodule

bind rrs_file rrs_file_chk #(.NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rrs_file.sv
`timescale 1ns/1ps
module tb_rrs_file;

    localparam int NREGS  = 4;
    localparam int TAG_W  = 3;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 2;
    localparam int NVEC   = 18;

    typedef struct packed {
        logic              iv;
        logic [IDX_W-1:0]  id;
        logic [TAG_W-1:0]  it;
        logic              cv;
        logic [TAG_W-1:0]  ct;
        logic [DATA_W-1:0] cd;
        logic [IDX_W-1:0]  ai;
        logic [IDX_W-1:0]  bi;
        logic              ar;
        logic [DATA_W-1:0] av;
        logic [TAG_W-1:0]  at;
        logic              br;
        logic [DATA_W-1:0] bv;
        logic [TAG_W-1:0]  bt;
        logic [3:0]        rq;
    } vec_t;

    function automatic vec_t mkv(int iv, int id, int it, int cv, int ct, int cd,
                                 int ai, int bi, int ar, int av, int at,
                                 int br, int bv, int bt, int rq);
        vec_t v;
        v.iv = 1'(iv); v.id = IDX_W'(id); v.it = TAG_W'(it);
        v.cv = 1'(cv); v.ct = TAG_W'(ct); v.cd = DATA_W'(cd);
        v.ai = IDX_W'(ai); v.bi = IDX_W'(bi);
        v.ar = 1'(ar); v.av = DATA_W'(av); v.at = TAG_W'(at);
        v.br = 1'(br); v.bv = DATA_W'(bv); v.bt = TAG_W'(bt);
        v.rq = 4'(rq);
        return v;
    endfunction

    // iv id it | cv ct cd | ai bi | ar av at | br bv bt | req
    localparam vec_t VECS [NVEC] = '{
        mkv(0,0,0, 0,0,0,       0,1, 1,0,0,       1,0,0,       1),  // R1 reset state
        mkv(1,1,3, 0,0,0,       1,2, 1,0,0,       1,0,0,       5),  // R5 issue cycle sees old state
        mkv(1,1,5, 0,0,0,       1,2, 0,0,3,       1,0,0,       3),  // R3 waiting on tag 3; retag to 5
        mkv(0,0,0, 1,3,'hAAAA,  1,0, 0,0,5,       1,0,0,       7),  // R7 stale producer
        mkv(0,0,0, 0,0,0,       1,0, 0,0,5,       1,0,0,       7),  // R7 stale result not stored
        mkv(0,0,0, 1,5,'h1234,  1,3, 1,'h1234,0,  1,0,0,       4),  // R4 bypass
        mkv(0,0,0, 0,0,0,       1,3, 1,'h1234,0,  1,0,0,       6),  // R6 captured
        mkv(1,2,6, 0,0,0,       1,2, 1,'h1234,0,  1,0,0,       5),  // R5
        mkv(1,2,7, 1,6,'h55,    2,1, 1,'h55,0,    1,'h1234,0,  8),  // R8 collision, read bypasses
        mkv(0,0,0, 0,0,0,       2,1, 0,0,7,       1,'h1234,0,  8),  // R8 new tag kept
        mkv(0,0,0, 1,7,'h77,    0,2, 1,0,0,       1,'h77,0,    4),  // R4 on port B
        mkv(1,3,0, 0,0,0,       3,2, 1,0,0,       1,'h77,0,    9),  // R9 null-tag issue
        mkv(0,0,0, 0,0,0,       3,2, 1,0,0,       1,'h77,0,    9),  // R9 ignored
        mkv(1,0,4, 0,0,0,       0,3, 1,0,0,       1,0,0,       5),  // R5
        mkv(1,3,4, 0,0,0,       0,3, 0,0,4,       1,0,0,       3),  // R3
        mkv(0,0,0, 0,4,'h99,    0,3, 0,0,4,       0,0,4,       9),  // R9 bc_valid low
        mkv(0,0,0, 1,4,'h4444,  0,3, 1,'h4444,0,  1,'h4444,0,  10), // R10 both bypass
        mkv(0,0,0, 0,0,0,       0,3, 1,'h4444,0,  1,'h4444,0,  10)  // R10 both captured
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [IDX_W-1:0]  iss_dst = '0;
    logic [TAG_W-1:0]  iss_tag = '0;
    logic [IDX_W-1:0]  rd_a_idx = '0;
    logic [IDX_W-1:0]  rd_b_idx = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_data = '0;
    logic              rd_a_rdy, rd_b_rdy;
    logic [DATA_W-1:0] rd_a_val, rd_b_val;
    logic [TAG_W-1:0]  rd_a_tag, rd_b_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rrs_file #(.NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rd_a_rdy(rd_a_rdy), .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag),
        .rd_b_rdy(rd_b_rdy), .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag)
    );

    task automatic check_port(string port, int rq,
                              logic r, logic [DATA_W-1:0] v, logic [TAG_W-1:0] t,
                              logic er, logic [DATA_W-1:0] ev, logic [TAG_W-1:0] et);
        checks++;
        if (r !== er || v !== ev || t !== et) begin
            errors++;
            $display("FAIL R%0d port %s: got rdy=%0b val=%h tag=%0d, expected rdy=%0b val=%h tag=%0d",
                     rq, port, r, v, t, er, ev, et);
        end
    endtask

    task automatic drive(logic iv, int id, int it, logic cv, int ct, logic [DATA_W-1:0] cd,
                         int ai, int bi);
        iss_valid = iv; iss_dst = IDX_W'(id); iss_tag = TAG_W'(it);
        bc_valid = cv; bc_tag = TAG_W'(ct); bc_data = cd;
        rd_a_idx = IDX_W'(ai); rd_b_idx = IDX_W'(bi);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            drive(VECS[k].iv, int'(VECS[k].id), int'(VECS[k].it),
                  VECS[k].cv, int'(VECS[k].ct), VECS[k].cd,
                  int'(VECS[k].ai), int'(VECS[k].bi));
            #1;
            check_port("A", int'(VECS[k].rq), rd_a_rdy, rd_a_val, rd_a_tag,
                       VECS[k].ar, VECS[k].av, VECS[k].at);
            check_port("B", int'(VECS[k].rq), rd_b_rdy, rd_b_val, rd_b_tag,
                       VECS[k].br, VECS[k].bv, VECS[k].bt);
        end

        // R1: reset in mid-run clears pending and completed registers
        @(negedge clk);
        drive(1'b1, 1, 2, 1'b0, 0, '0, 1, 2);
        @(negedge clk);
        drive(1'b0, 0, 0, 1'b0, 0, '0, 1, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_port("A", 1, rd_a_rdy, rd_a_val, rd_a_tag, 1'b1, '0, '0); // R1 pending cleared
        check_port("B", 1, rd_b_rdy, rd_b_val, rd_b_tag, 1'b1, '0, '0); // R1 value cleared

        // R9: null-tag broadcast does not touch a settled register
        @(negedge clk);
        drive(1'b1, 0, 1, 1'b0, 0, '0, 0, 0);
        @(negedge clk);
        drive(1'b0, 0, 0, 1'b1, 1, 32'hBEEF, 0, 0);
        @(negedge clk);
        drive(1'b0, 0, 0, 1'b1, 0, 32'hDEAD, 0, 1);
        #1;
        check_port("A", 6, rd_a_rdy, rd_a_val, rd_a_tag, 1'b1, 32'hBEEF, '0); // R6 captured
        check_port("B", 9, rd_b_rdy, rd_b_val, rd_b_tag, 1'b1, '0, '0);      // R9 ready reg unaffected
        @(negedge clk);
        drive(1'b0, 0, 0, 1'b0, 0, '0, 0, 1);
        #1;
        check_port("A", 9, rd_a_rdy, rd_a_val, rd_a_tag, 1'b1, 32'hBEEF, '0); // R9 null-tag ignored

        // R2: waiting register returns tag; R3 on port B
        @(negedge clk);
        drive(1'b1, 1, 6, 1'b0, 0, '0, 0, 1);
        @(negedge clk);
        drive(1'b0, 0, 0, 1'b1, 2, 32'h1, 0, 1);
        #1;
        check_port("A", 2, rd_a_rdy, rd_a_val, rd_a_tag, 1'b1, 32'hBEEF, '0); // R2
        check_port("B", 3, rd_b_rdy, rd_b_val, rd_b_tag, 1'b0, '0, 3'd6);     // R3

        @(negedge clk);
        finish_run();
    end

endmodule